// File: doc/BRIEF.md
# Burst Read Ready Generator

This block runs on the device side of a synchronous burst-mode memory. During a clocked burst read it drives the ready line that tells the host whether the word on the bus may be taken. A low ready means the host must wait, and must not sample the next word until ready is high again. The block also tracks the word address of the burst as it advances.

A burst begins when `burst_start` is seen while `burst_enable` is high. Ready is then held low for a fixed initial latency. After that, one word is delivered in each cycle in which ready is high. Ready drops again for a short penalty each time the burst crosses a 64-word block boundary. When the static slow-clock flag is set, ready also drops on every third streaming cycle. Outside a burst, ready stays high. The exception is a clocked status read, during which ready follows the status-valid input.

The memory array, the command decoder and the clock-frequency detection sit outside this block.

Top module: `burst_ready_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters idle: `rdy` is 1 and `word_addr` is 0.
- R2: In idle with `status_rd` low, `rdy` is 1.
- R3: A clock edge with `burst_enable` = 1 and `burst_start` = 1 loads `word_addr` with `start_addr`. `rdy` is then 0 for exactly INIT_LAT cycles (default 5), starting in the cycle after that edge.
- R4: After the latency, each cycle with `rdy` = 1 delivers the word at `word_addr`, and `word_addr` rises by one at the next edge. It wraps modulo 2^ADDR_W.
- R5: Delivering a word whose address has low six bits equal to 6'h3E is followed by BND_PEN cycles (default 2) with `rdy` = 0. During those cycles `word_addr` already holds the next address. Streaming then resumes.
- R6: With `slow_clk` = 1, ready follows the pattern high, high, low while streaming. The pattern restarts at the start of streaming and again after each boundary wait. `word_addr` holds during the low cycle.
- R7: In idle with `status_rd` = 1, `rdy` equals `status_valid` in the same cycle.
- R8: A clock edge with `burst_enable` = 0 returns the block to idle, with `word_addr` = 0. This takes effect in any state.
- R9: `burst_start` has no effect while `burst_enable` is 0. A `burst_start` during an active burst restarts the latency at the new `start_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_enable | input | 1 | High while a burst read is allowed; low clears the sequencer |
| burst_start | input | 1 | Single-cycle strobe that begins a burst |
| start_addr | input | ADDR_W | First word address of the burst |
| slow_clk | input | 1 | Static flag: clock is below the slow threshold |
| status_rd | input | 1 | A clocked status read is in progress |
| status_valid | input | 1 | Status data is valid |
| rdy | output | 1 | Ready to the host, low means wait |
| word_addr | output | ADDR_W | Address of the current burst word |

## Verification
A latency counter that is wrong by one shifts the first high `rdy` by a cycle. The address is then compared against its expected value in every following cycle, so an off-by-one here shows within the first delivered word. A boundary detector on the wrong address, or a penalty of the wrong length, shows as an unexpected low or high `rdy` right after word 3Eh of a block. An address that skips or stalls shows on `word_addr` on the very next cycle. A slow-clock phase that is not restarted after a boundary wait, or after the latency, moves the third-cycle hole. This is visible within three cycles of streaming resuming.

// File: rtl/brg_pkg.sv
// Shared types for the burst read ready generator.
package brg_pkg;

    // Sequencer states of the ready generator.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAT    = 2'd1,
        ST_STREAM = 2'd2,
        ST_BWAIT  = 2'd3
    } brg_state_e;

endpackage

// File: rtl/brg_wait_ctr.sv
// Down-counter for wait windows (initial latency and boundary penalty).
// Assumes LOAD_A and LOAD_B are at least 1. A load sets the count to the
// window length minus one, so done rises in the last cycle of the window.
module brg_wait_ctr #(
    parameter int LOAD_A = 5,
    parameter int LOAD_B = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ld_a,
    input  logic ld_b,
    output logic done
);
    localparam int MAXV = (LOAD_A > LOAD_B) ? LOAD_A : LOAD_B;
    localparam int CW   = (MAXV < 2) ? 1 : $clog2(MAXV);
    localparam logic [CW-1:0] VAL_A = CW'(LOAD_A - 1);
    localparam logic [CW-1:0] VAL_B = CW'(LOAD_B - 1);

    logic [CW-1:0] cnt_q;

    // Load a window length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (ld_a) begin
            cnt_q <= VAL_A;
        end else if (ld_b) begin
            cnt_q <= VAL_B;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Window ends when the count reaches zero.
    assign done = (cnt_q == '0);
endmodule

// File: rtl/brg_slow_phase.sv
// Phase generator that inserts one hold cycle in every DIV streaming cycles
// when the slow-clock flag is set. The phase restarts whenever run is low.
// A DIV below 2 builds no logic and never holds.
module brg_slow_phase #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic hold
);
    generate
        if (DIV < 2) begin : g_none
            assign hold = 1'b0;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] ph_q;

            // Advance the phase while streaming; restart otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    ph_q <= '0;
                end else if (ph_q == LAST) begin
                    ph_q <= '0;
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end

            // Hold on the last phase slot only in slow mode.
            assign hold = slow && (ph_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/brg_addr_ctr.sv
// Burst word address counter with block-boundary detection.
// Assumes BLK_WORDS is a power of two and BND_OFS < BLK_WORDS. at_bnd is
// high when the current word sits at offset BND_OFS within its block.
module brg_addr_ctr #(
    parameter int ADDR_W    = 22,
    parameter int BLK_WORDS = 64,
    parameter int BND_OFS   = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_bnd
);
    localparam int OFS_W = $clog2(BLK_WORDS);
    localparam logic [OFS_W-1:0] BND_VAL = OFS_W'(BND_OFS);

    logic [ADDR_W-1:0] addr_q;

    // Clear, load the start address, or step after a delivered word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr   = addr_q;
    // Compare the in-block offset against the boundary word.
    assign at_bnd = (addr_q[OFS_W-1:0] == BND_VAL);
endmodule

// File: rtl/burst_ready_gen.sv
// Ready generator for clocked burst reads.
// Sequences idle -> initial latency -> streaming, with boundary waits in
// between. It drives rdy low whenever the host must hold off. Assumes
// slow_clk is static during a burst, and that burst_start is a single-cycle
// strobe qualified by burst_enable.
module burst_ready_gen #(
    parameter int ADDR_W    = 22,
    parameter int INIT_LAT  = 5,
    parameter int BLK_WORDS = 64,
    parameter int BND_OFS   = 62,
    parameter int BND_PEN   = 2,
    parameter int SLOW_DIV  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_enable,
    input  logic              burst_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              slow_clk,
    input  logic              status_rd,
    input  logic              status_valid,
    output logic              rdy,
    output logic [ADDR_W-1:0] word_addr
);
    import brg_pkg::*;

    brg_state_e state_q, state_d;
    logic start_ok, streaming, slow_hold, deliver;
    logic at_bnd, wait_done, ld_pen;

    assign start_ok  = burst_enable && burst_start;
    assign streaming = (state_q == ST_STREAM);
    assign deliver   = streaming && !slow_hold;
    assign ld_pen    = burst_enable && !burst_start && deliver && at_bnd;

    brg_slow_phase #(.DIV(SLOW_DIV)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (streaming),
        .slow  (slow_clk),
        .hold  (slow_hold)
    );

    brg_wait_ctr #(.LOAD_A(INIT_LAT), .LOAD_B(BND_PEN)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!burst_enable),
        .ld_a  (start_ok),
        .ld_b  (ld_pen),
        .done  (wait_done)
    );

    brg_addr_ctr #(
        .ADDR_W    (ADDR_W),
        .BLK_WORDS (BLK_WORDS),
        .BND_OFS   (BND_OFS)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!burst_enable),
        .load     (start_ok),
        .load_val (start_addr),
        .inc      (deliver),
        .addr     (word_addr),
        .at_bnd   (at_bnd)
    );

    // Next-state selection; enable-low and restart take priority.
    always_comb begin
        state_d = state_q;
        if (!burst_enable) begin
            state_d = ST_IDLE;
        end else if (burst_start) begin
            state_d = ST_LAT;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_LAT:    if (wait_done) state_d = ST_STREAM;
                ST_STREAM: if (deliver && at_bnd) state_d = ST_BWAIT;
                ST_BWAIT:  if (wait_done) state_d = ST_STREAM;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Ready: high in idle unless a status read awaits valid data; during a
    // burst, high only in streaming cycles that deliver a word.
    always_comb begin
        if (state_q == ST_IDLE) begin
            rdy = status_rd ? status_valid : 1'b1;
        end else begin
            rdy = deliver;
        end
    end
endmodule

// File: rtl/burst_ready_gen_chk.sv
// Property checker for burst_ready_gen, attached through bind.
// Observes ports and the sequencer state register.
module burst_ready_gen_chk #(
    parameter int ADDR_W    = 22,
    parameter int BLK_WORDS = 64,
    parameter int BND_OFS   = 62
) (
    input logic              clk,
    input logic              rst_n,
    input logic              burst_enable,
    input logic              burst_start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              slow_clk,
    input logic              status_rd,
    input logic              status_valid,
    input logic              rdy,
    input logic [ADDR_W-1:0] word_addr,
    input brg_pkg::brg_state_e state_q
);
    import brg_pkg::*;
    localparam int OFS_W = $clog2(BLK_WORDS);

    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !status_rd) |-> rdy);

    p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_enable && burst_start) |=> (!rdy && word_addr == $past(start_addr)));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && rdy && burst_enable && !burst_start)
        |=> ((word_addr - $past(word_addr)) == ADDR_W'(1)));

    p_bnd_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && rdy && burst_enable && !burst_start &&
         word_addr[OFS_W-1:0] == OFS_W'(BND_OFS))
        |=> (!rdy && state_q == ST_BWAIT));

    p_slow_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && !rdy) |-> slow_clk);

    p_status_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && status_rd) |-> (rdy == status_valid));

    p_enable_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_enable |=> (state_q == ST_IDLE && word_addr == '0));
endmodule

bind burst_ready_gen burst_ready_gen_chk #(
    .ADDR_W    (ADDR_W),
    .BLK_WORDS (BLK_WORDS),
    .BND_OFS   (BND_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_enable (burst_enable),
    .burst_start  (burst_start),
    .start_addr   (start_addr),
    .slow_clk     (slow_clk),
    .status_rd    (status_rd),
    .status_valid (status_valid),
    .rdy          (rdy),
    .word_addr    (word_addr),
    .state_q      (state_q)
);

// File: tb/tb_burst_ready_gen.sv
module tb_burst_ready_gen;
    localparam int AW  = 22;
    localparam int LAT = 5;
    localparam int PEN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_enable = 1'b0;
    logic burst_start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic slow_clk = 1'b0;
    logic status_rd = 1'b0;
    logic status_valid = 1'b0;
    logic rdy;
    logic [AW-1:0] word_addr;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    burst_ready_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_enable (burst_enable),
        .burst_start  (burst_start),
        .start_addr   (start_addr),
        .slow_clk     (slow_clk),
        .status_rd    (status_rd),
        .status_valid (status_valid),
        .rdy          (rdy),
        .word_addr    (word_addr)
    );

    typedef struct packed {
        logic [AW-1:0] sa;
        logic          lf;
        logic [7:0]    ncyc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{22'h000000, 1'b0, 8'd20},
        '{22'h00003A, 1'b0, 8'd24},
        '{22'h00007C, 1'b1, 8'd40},
        '{22'h3FFFFC, 1'b0, 8'd20},
        '{22'h000040, 1'b1, 8'd16},
        '{22'h00013E, 1'b1, 8'd14}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    endtask

    // Start a burst and compare every cycle against a model of the rules.
    task automatic run_burst(input logic [AW-1:0] sa, input logic lf, input int ncyc);
        int lat = LAT;
        int pen = 0;
        int ph = 0;
        logic [AW-1:0] ma = sa;
        @(negedge clk);
        burst_enable = 1'b1;
        burst_start = 1'b1;
        start_addr = sa;
        slow_clk = lf;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            burst_start = 1'b0;
            if (lat > 0) begin
                check("R3 rdy", {31'd0, rdy}, 32'd0);
                check("R3 addr", {10'd0, word_addr}, {10'd0, ma});
                lat--;
            end else if (pen > 0) begin
                check("R5 rdy", {31'd0, rdy}, 32'd0);
                check("R5 addr", {10'd0, word_addr}, {10'd0, ma});
                pen--;
            end else if (lf && ph == 2) begin
                check("R6 rdy", {31'd0, rdy}, 32'd0);
                check("R6 addr", {10'd0, word_addr}, {10'd0, ma});
                ph = 0;
            end else begin
                check("R4 rdy", {31'd0, rdy}, 32'd1);
                check("R4 addr", {10'd0, word_addr}, {10'd0, ma});
                if (ma[5:0] == 6'h3E) begin
                    pen = PEN;
                    ph = 0;
                end else begin
                    ph = (ph + 1) % 3;
                end
                ma = ma + 1'b1;
            end
        end
        burst_enable = 1'b0;
        slow_clk = 1'b0;
        @(negedge clk);
        check("R8 rdy", {31'd0, rdy}, 32'd1);
        check("R8 addr", {10'd0, word_addr}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rdy", {31'd0, rdy}, 32'd1);
        check("R1 addr", {10'd0, word_addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle rdy", {31'd0, rdy}, 32'd1);

        // R7: status read, rdy follows status_valid
        status_rd = 1'b1;
        status_valid = 1'b0;
        #1 check("R7 not valid", {31'd0, rdy}, 32'd0);
        @(negedge clk);
        check("R7 still not valid", {31'd0, rdy}, 32'd0);
        status_valid = 1'b1;
        #1 check("R7 valid", {31'd0, rdy}, 32'd1);
        @(negedge clk);
        status_rd = 1'b0;
        status_valid = 1'b0;
        #1 check("R2 after status", {31'd0, rdy}, 32'd1);

        // R9: strobe without enable is ignored
        @(negedge clk);
        burst_start = 1'b1;
        start_addr = 22'h000055;
        @(negedge clk);
        burst_start = 1'b0;
        check("R9 ignored rdy", {31'd0, rdy}, 32'd1);
        check("R9 ignored addr", {10'd0, word_addr}, 32'd0);

        // Vector walk: R3, R4, R5, R6, R8
        for (int k = 0; k < 6; k++) begin
            run_burst(VECS[k].sa, VECS[k].lf, int'(VECS[k].ncyc));
        end

        // R8: abort during the initial latency
        @(negedge clk);
        burst_enable = 1'b1;
        burst_start = 1'b1;
        start_addr = 22'h000123;
        @(negedge clk);
        burst_start = 1'b0;
        @(negedge clk);
        check("R8 latency low", {31'd0, rdy}, 32'd0);
        burst_enable = 1'b0;
        @(negedge clk);
        check("R8 abort rdy", {31'd0, rdy}, 32'd1);
        check("R8 abort addr", {10'd0, word_addr}, 32'd0);

        // R9: restart during streaming
        @(negedge clk);
        burst_enable = 1'b1;
        burst_start = 1'b1;
        start_addr = 22'h000010;
        @(negedge clk);
        burst_start = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        check("R4 before restart rdy", {31'd0, rdy}, 32'd1);
        check("R4 before restart addr", {10'd0, word_addr}, 32'h12);
        burst_start = 1'b1;
        start_addr = 22'h000200;
        for (int i = 0; i < LAT; i++) begin
            @(negedge clk);
            burst_start = 1'b0;
            check("R9 restart rdy", {31'd0, rdy}, 32'd0);
            check("R9 restart addr", {10'd0, word_addr}, 32'h200);
        end
        @(negedge clk);
        check("R9 restart first word", {31'd0, rdy}, 32'd1);
        burst_enable = 1'b0;
        @(negedge clk);
        check("R8 final", {10'd0, word_addr}, 32'd0);

        // R1: reset in mid burst
        burst_enable = 1'b1;
        burst_start = 1'b1;
        start_addr = 22'h000077;
        @(negedge clk);
        burst_start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        burst_enable = 1'b0;
        check("R1 mid reset rdy", {31'd0, rdy}, 32'd1);
        check("R1 mid reset addr", {10'd0, word_addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule